// File: doc/BRIEF.md
# SDRAM Per-Bank Command Legality Monitor

This block sits passively on an SDRAM command bus and judges every command it sees against the state of the bank it addresses. For each bank it keeps one of eight states: idle, opening a row, row open, read burst, write burst, read burst with auto close, write burst with auto close, and closing. Timed states are governed by cycle counts set as parameters: the row-to-column delay, the close (precharge) time and the burst length. A command that the addressed bank may not accept in its present state raises that bank's violation flag for one cycle.

The monitor drives nothing onto the bus and models no data. It is meant to be placed beside a memory controller, in simulation or in silicon, so that a controller fault shows up as a flag on the exact bank and cycle where it happened. An illegal command is reported and otherwise dropped: the bank keeps its state and its timer keeps running, so a single fault does not cascade into a stream of false reports.

Top module: `sdram_bank_guard`

## Requirements
- R1: Commands decode from (cs_n, ras_n, cas_n, we_n): cs_n=1 inhibit, 0111 no-op, 0011 open row, 0101 read, 0100 write, 0110 burst stop, 0010 close row, 0001 refresh, 0000 mode load; inhibit and no-op never raise a flag in any state.
- R2: A command counts only if cke was 1 on both the current and the previous clock edge; otherwise it raises no flag and changes no bank state. cke is taken as 0 on the first edge after reset.
- R3: An idle bank accepts open row, close row (stays idle), refresh and mode load; read, write and burst stop to an idle bank raise its flag.
- R4: After open row at edge k, the bank is opening until edge k+T_RCD, at which it has an open row; any command other than inhibit or no-op to it during edges k+1 to k+T_RCD-1 raises its flag.
- R5: A bank with an open row accepts read, write and close row; open row and burst stop raise its flag.
- R6: During a read or write burst the bank accepts a new read or write (restarting the burst), close row (truncating it) and burst stop (returning to open row); open row raises its flag.
- R7: A read or write at edge k with the auto-close bit (ap) low leaves the bank with an open row at edge k+BURST_LEN.
- R8: After close row at edge k the bank is closing and is idle at edge k+T_RP; any other command to it before then raises its flag.
- R9: A read or write with ap high at edge k locks the bank until edge k+BURST_LEN+T_RP, when it is idle; any command other than inhibit or no-op to it before then raises its flag.
- R10: Close row with ap high applies to every bank, each judged by its own state; a bank already idle stays idle.
- R11: Refresh and mode load raise the flag of every bank that is not idle and raise none when all banks are idle.
- R12: Open row, read, write, burst stop and close row with ap low address only the bank on ba; no other bank's flag or state is affected, and an illegal command leaves the addressed bank's state unchanged.
- R13: The flag for a command at edge k is high between edges k and k+1 only; reset returns every bank to idle with all flags low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| ap | input | 1 | Auto-close / all-banks address bit |
| viol | output | NUM_BANKS | Per-bank violation pulse, one bit per bank |

## Verification
The bench aims at the exact edges where timed states end: a read one cycle before the row-to-column delay is over must be flagged and one cycle later must pass, and the same off-by-one probe is made on the close time and on the combined burst-plus-close lock; a counter that is one short or one long flips one of those checks. Burst stop is probed both inside a burst and right after the burst has run out, which catches a design that never returns to open row or returns a cycle late. A close-all issued while banks sit in mixed states, and a refresh with some banks busy, catch logic that applies a global command to one bank only. Clock-enable gating is tested on the edge after cke rises, where a design that looks only at the current cke would wrongly flag, and a reset taken with a row open is followed by a read that must now be flagged.

// File: rtl/sdram_bank_guard_pkg.sv
// Shared command and bank-state encodings for the SDRAM bank guard.
// Assumes: four-bit command space and three-bit state space are enough.
package sdram_bank_guard_pkg;

    typedef enum logic [3:0] {
        C_INHIBIT,
        C_NOP,
        C_OPEN,
        C_READ,
        C_WRITE,
        C_STOP,
        C_CLOSE,
        C_REFRESH,
        C_MODE
    } sbg_cmd_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPENING,
        S_OPEN,
        S_RD,
        S_WR,
        S_RD_AP,
        S_WR_AP,
        S_CLOSING
    } sbg_state_e;

    localparam int STATE_W = 3;

endpackage

// File: rtl/sdram_bank_guard_decode.sv
// Turns the raw strobe levels into a command code and says whether the
// command is live, i.e. clock enable was high on this and the last edge.
// Assumes: synchronous active-low reset; cke treated low before first edge.
module sdram_bank_guard_decode
    import sdram_bank_guard_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sbg_cmd_e cmd_o,
    output logic     live_o
);

    logic cke_q;

    // Remember clock enable from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b0;
        end else begin
            cke_q <= cke;
        end
    end

    // Map the strobe pattern onto a command code.
    always_comb begin
        if (cs_n) begin
            cmd_o = C_INHIBIT;
        end else begin
            unique case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o = C_NOP;
                3'b011:  cmd_o = C_OPEN;
                3'b101:  cmd_o = C_READ;
                3'b100:  cmd_o = C_WRITE;
                3'b110:  cmd_o = C_STOP;
                3'b010:  cmd_o = C_CLOSE;
                3'b001:  cmd_o = C_REFRESH;
                default: cmd_o = C_MODE;
            endcase
        end
    end

    // A command is only judged when cke held high across two edges.
    assign live_o = cke & cke_q;

endmodule

// File: rtl/sdram_bank_guard_bank.sv
// Tracks one bank: its state, a countdown for the timed states, and a
// registered violation pulse for commands the state does not allow.
// Assumes: hit_i already folds in bank address and all-bank commands;
// an illegal command leaves state alone while the countdown keeps going.
module sdram_bank_guard_bank
    import sdram_bank_guard_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       live_i,
    input  sbg_cmd_e   cmd_i,
    input  logic       hit_i,
    input  logic       ap_i,
    output sbg_state_e state_o,
    output logic       viol_o
);

    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_BL  = CNT_W'(BURST_LEN - 1);
    localparam logic [CNT_W-1:0] LD_AP  = CNT_W'(BURST_LEN + T_RP - 1);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

    sbg_state_e       st_q, st_nxt;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             bad;

    // Next state: timer expiry first, then any command aimed at this bank.
    always_comb begin
        st_nxt  = st_q;
        cnt_nxt = cnt_q;
        bad     = 1'b0;

        case (st_q)
            S_OPENING: begin
                if (cnt_q <= ONE) st_nxt = S_OPEN;
                else              cnt_nxt = cnt_q - ONE;
            end
            S_RD, S_WR: begin
                if (cnt_q <= ONE) st_nxt = S_OPEN;
                else              cnt_nxt = cnt_q - ONE;
            end
            S_RD_AP, S_WR_AP, S_CLOSING: begin
                if (cnt_q <= ONE) st_nxt = S_IDLE;
                else              cnt_nxt = cnt_q - ONE;
            end
            default: ;
        endcase

        if (live_i && hit_i) begin
            case (cmd_i)
                C_REFRESH, C_MODE: begin
                    bad = (st_q != S_IDLE);
                end
                C_OPEN: begin
                    if (st_q == S_IDLE) begin
                        st_nxt  = (T_RCD > 1) ? S_OPENING : S_OPEN;
                        cnt_nxt = LD_RCD;
                    end else begin
                        bad = 1'b1;
                    end
                end
                C_CLOSE: begin
                    case (st_q)
                        S_IDLE: st_nxt = S_IDLE;
                        S_OPEN, S_RD, S_WR: begin
                            st_nxt  = (T_RP > 1) ? S_CLOSING : S_IDLE;
                            cnt_nxt = LD_RP;
                        end
                        default: bad = 1'b1;
                    endcase
                end
                C_READ, C_WRITE: begin
                    if (st_q == S_OPEN || st_q == S_RD || st_q == S_WR) begin
                        if (ap_i) begin
                            st_nxt  = (cmd_i == C_READ) ? S_RD_AP : S_WR_AP;
                            cnt_nxt = LD_AP;
                        end else begin
                            if (BURST_LEN > 1)
                                st_nxt = (cmd_i == C_READ) ? S_RD : S_WR;
                            else
                                st_nxt = S_OPEN;
                            cnt_nxt = LD_BL;
                        end
                    end else begin
                        bad = 1'b1;
                    end
                end
                C_STOP: begin
                    if (st_q == S_RD || st_q == S_WR) st_nxt = S_OPEN;
                    else                              bad    = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Register state, countdown and the violation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            cnt_q  <= '0;
            viol_o <= 1'b0;
        end else begin
            st_q   <= st_nxt;
            cnt_q  <= cnt_nxt;
            viol_o <= bad;
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/sdram_bank_guard.sv
// Passive legality monitor for an SDRAM command bus. Decodes each command,
// works out which banks it addresses and lets one tracker per bank judge it.
// Assumes: T_RCD, T_RP, BURST_LEN are at least 1; bus sampled on rising clk.
module sdram_bank_guard
    import sdram_bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int BURST_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_W-1:0]      ba,
    input  logic                 ap,
    output logic [NUM_BANKS-1:0] viol
);

    localparam int LONGEST = (T_RCD > BURST_LEN + T_RP) ? T_RCD : BURST_LEN + T_RP;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    sbg_cmd_e                       cmd;
    logic                           live;
    logic [NUM_BANKS-1:0]           hit;
    logic [NUM_BANKS*STATE_W-1:0]   st_flat;

    sdram_bank_guard_decode u_decode (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .cs_n   (cs_n),
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cmd_o  (cmd),
        .live_o (live)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sbg_state_e st_b;

        // Decide whether the current command reaches this bank.
        always_comb begin
            case (cmd)
                C_OPEN, C_READ, C_WRITE, C_STOP: hit[b] = (ba == BA_W'(b));
                C_CLOSE:                         hit[b] = ap || (ba == BA_W'(b));
                C_REFRESH, C_MODE:               hit[b] = 1'b1;
                default:                         hit[b] = 1'b0;
            endcase
        end

        sdram_bank_guard_bank #(
            .T_RCD     (T_RCD),
            .T_RP      (T_RP),
            .BURST_LEN (BURST_LEN),
            .CNT_W     (CNT_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .live_i  (live),
            .cmd_i   (cmd),
            .hit_i   (hit[b]),
            .ap_i    (ap),
            .state_o (st_b),
            .viol_o  (viol[b])
        );

        assign st_flat[b*STATE_W +: STATE_W] = st_b;
    end

endmodule

// File: rtl/sdram_bank_guard_chk.sv
// Property checker for the SDRAM bank guard, bound onto every instance.
// Assumes: bank states arrive packed, STATE_W bits per bank.
module sdram_bank_guard_chk
    import sdram_bank_guard_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int T_RCD     = 3
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cke,
    input logic                         cs_n,
    input logic                         ras_n,
    input logic                         cas_n,
    input logic                         we_n,
    input logic [BA_W-1:0]              ba,
    input logic                         ap,
    input logic [NUM_BANKS-1:0]         viol,
    input logic [NUM_BANKS*STATE_W-1:0] bank_st
);

    logic all_idle;

    // Collect whether every bank currently reports idle.
    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st[i*STATE_W +: STATE_W] != S_IDLE) all_idle = 1'b0;
        end
    end

    // R1: a flag always traces back to a real command, never no-op/inhibit.
    p_quiet_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (viol != '0) |-> $past(!cs_n && !(ras_n && cas_n && we_n)));

    // R2: a flag needs cke high on both edges around the command.
    p_cke_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (viol != '0) |-> ($past(cke) && $past(cke, 2)));

    // R12: only refresh, mode load or close-all can flag several banks.
    p_spread_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(viol) > 1) |->
            $past(!cs_n && ((!ras_n && !cas_n) || (!ras_n && cas_n && !we_n && ap))));

    // R11: refresh or mode load with all banks idle raises nothing.
    p_refresh_ok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cke && $past(cke) && !cs_n && !ras_n && !cas_n && all_idle)
            |=> (viol == '0));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
        logic [STATE_W-1:0] s;
        assign s = bank_st[b*STATE_W +: STATE_W];

        // R4: open row on an idle bank enters the opening state.
        p_open_enters_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && cke && $past(cke) && !cs_n && !ras_n && cas_n && we_n
             && ba == BA_W'(b) && s == S_IDLE)
                |=> (s == ((T_RCD > 1) ? S_OPENING : S_OPEN)));
    end

endmodule

bind sdram_bank_guard sdram_bank_guard_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BA_W      (BA_W),
    .T_RCD     (T_RCD)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke     (cke),
    .cs_n    (cs_n),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .ba      (ba),
    .ap      (ap),
    .viol    (viol),
    .bank_st (st_flat)
);

// File: tb/sdram_bank_guard_bench.sv
// Vector-driven bench for the SDRAM bank guard (T_RCD=3, T_RP=3, BURST_LEN=4).
module sdram_bank_guard_bench;

    localparam logic [3:0] K_INH = 4'b1000;
    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_RD  = 4'b0101;
    localparam logic [3:0] K_WR  = 4'b0100;
    localparam logic [3:0] K_BST = 4'b0110;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_LMR = 4'b0000;

    localparam int NV = 48;
    // {req[15:12], cke[11], cmd[10:7], ba[6:5], ap[4], expected viol[3:0]}
    localparam logic [15:0] VEC [NV] = '{
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 0  R1
        {4'd3,  1'b1, K_RD,  2'd0, 1'b0, 4'b0001}, // 1  R3 read to idle
        {4'd3,  1'b1, K_ACT, 2'd0, 1'b0, 4'b0000}, // 2  R3 open b0
        {4'd4,  1'b1, K_WR,  2'd0, 1'b0, 4'b0001}, // 3  R4
        {4'd4,  1'b1, K_RD,  2'd0, 1'b0, 4'b0001}, // 4  R4 one early
        {4'd4,  1'b1, K_RD,  2'd0, 1'b0, 4'b0000}, // 5  R4 on time
        {4'd12, 1'b1, K_ACT, 2'd1, 1'b0, 4'b0000}, // 6  R12 other bank
        {4'd6,  1'b1, K_ACT, 2'd0, 1'b0, 4'b0001}, // 7  R6 open in burst
        {4'd13, 1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 8  R13 pulse
        {4'd7,  1'b1, K_BST, 2'd0, 1'b0, 4'b0001}, // 9  R7 burst ran out
        {4'd5,  1'b1, K_WR,  2'd1, 1'b0, 4'b0000}, // 10 R5
        {4'd6,  1'b1, K_BST, 2'd1, 1'b0, 4'b0000}, // 11 R6
        {4'd5,  1'b1, K_BST, 2'd1, 1'b0, 4'b0010}, // 12 R5
        {4'd8,  1'b1, K_PRE, 2'd0, 1'b0, 4'b0000}, // 13 R8 close b0
        {4'd5,  1'b1, K_ACT, 2'd1, 1'b0, 4'b0010}, // 14 R5
        {4'd8,  1'b1, K_ACT, 2'd0, 1'b0, 4'b0001}, // 15 R8 one early
        {4'd8,  1'b1, K_ACT, 2'd0, 1'b0, 4'b0000}, // 16 R8 on time
        {4'd11, 1'b1, K_REF, 2'd0, 1'b0, 4'b0011}, // 17 R11 busy banks
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 18 R1
        {4'd9,  1'b1, K_RD,  2'd0, 1'b1, 4'b0000}, // 19 R9 read auto-close
        {4'd8,  1'b1, K_PRE, 2'd1, 1'b0, 4'b0000}, // 20 R8 close b1
        {4'd9,  1'b1, K_RD,  2'd0, 1'b0, 4'b0001}, // 21 R9
        {4'd13, 1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 22 R13
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 23 R1
        {4'd9,  1'b1, K_PRE, 2'd0, 1'b0, 4'b0001}, // 24 R9
        {4'd9,  1'b1, K_ACT, 2'd0, 1'b0, 4'b0001}, // 25 R9 one early
        {4'd9,  1'b1, K_ACT, 2'd0, 1'b0, 4'b0000}, // 26 R9 on time
        {4'd11, 1'b1, K_LMR, 2'd0, 1'b0, 4'b0001}, // 27 R11
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 28 R1
        {4'd5,  1'b1, K_WR,  2'd0, 1'b0, 4'b0000}, // 29 R5
        {4'd3,  1'b1, K_ACT, 2'd2, 1'b0, 4'b0000}, // 30 R3
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 31 R1
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 32 R1
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 33 R1
        {4'd10, 1'b1, K_PRE, 2'd3, 1'b1, 4'b0000}, // 34 R10 close all
        {4'd10, 1'b1, K_ACT, 2'd3, 1'b0, 4'b0000}, // 35 R10 b3 stayed idle
        {4'd10, 1'b1, K_PRE, 2'd1, 1'b1, 4'b1101}, // 36 R10 mixed states
        {4'd11, 1'b1, K_REF, 2'd0, 1'b0, 4'b1000}, // 37 R11
        {4'd10, 1'b1, K_PRE, 2'd0, 1'b1, 4'b0000}, // 38 R10
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 39 R1
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}, // 40 R1
        {4'd11, 1'b1, K_REF, 2'd0, 1'b0, 4'b0000}, // 41 R11 all idle
        {4'd11, 1'b1, K_LMR, 2'd0, 1'b0, 4'b0000}, // 42 R11 all idle
        {4'd2,  1'b0, K_RD,  2'd0, 1'b0, 4'b0000}, // 43 R2 cke low
        {4'd2,  1'b1, K_RD,  2'd0, 1'b0, 4'b0000}, // 44 R2 cke just rose
        {4'd2,  1'b1, K_RD,  2'd0, 1'b0, 4'b0001}, // 45 R2 judged again
        {4'd1,  1'b1, K_INH, 2'd0, 1'b0, 4'b0000}, // 46 R1 inhibit
        {4'd1,  1'b1, K_NOP, 2'd0, 1'b0, 4'b0000}  // 47 R1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = 2'd0;
    logic       ap = 1'b0;
    logic [3:0] viol;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    sdram_bank_guard u_sdram_bank_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .ap    (ap),
        .viol  (viol)
    );

    task automatic drive(input logic k, input logic [3:0] c, input logic [1:0] b, input logic a);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = c;
        ba = b;
        ap = a;
    endtask

    task automatic check(input int req, input logic [3:0] exp, input string what);
        n_checks++;
        if (viol !== exp) begin
            n_fails++;
            $display("FAIL R%0d %s: viol=%b expected %b", req, what, viol, exp);
        end
    endtask

    initial begin
        #800000;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        drive(1'b1, K_NOP, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        check(13, 4'b0000, "R13 flags low in reset");

        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][11], VEC[i][10:7], VEC[i][6:5], VEC[i][4]);
            @(negedge clk);
            check(int'(VEC[i][15:12]), VEC[i][3:0], $sformatf("vector %0d", i));
        end

        // R13: reset with a row open must bring the bank back to idle.
        drive(1'b1, K_ACT, 2'd0, 1'b0);
        @(negedge clk);
        check(3, 4'b0000, "R3 open before reset");
        drive(1'b1, K_NOP, 2'd0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        drive(1'b1, K_RD, 2'd0, 1'b0);
        @(negedge clk);
        check(13, 4'b0000, "R13 no flag during reset");
        @(negedge clk);
        check(13, 4'b0000, "R13 no flag during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(2, 4'b0000, "R2 first edge after reset ignored");
        @(negedge clk);
        check(13, 4'b0001, "R13 bank idle after reset");
        drive(1'b1, K_NOP, 2'd0, 1'b0);
        @(negedge clk);
        check(13, 4'b0000, "R13 pulse lasts one cycle");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule